// File: doc/BRIEF.md
# Superframe Sync Lock Tracker

This block watches a byte stream that has already been aligned to transport packets. It looks for a superframe marker. Every eighth packet starts with the marker byte B8h, and every other packet starts with the ordinary sync byte 47h. Only the first byte of each packet is examined. That byte is called a head, and a head is any byte presented with both the valid and packet-start strobes high.

The block runs a three-state machine: hunt, acquire and lock. In hunt, the first B8h head fixes the superframe phase. In acquire, the block counts markers that arrive at the expected phase, and it enters lock once a programmed number of them have been seen in a row. In lock, it counts consecutive wrong heads and falls back to hunt once a second programmed number is reached.

The lock state drives a status output. It also drives a frame-sync output, which a mode input can switch over to an upstream sync signal instead.

Top module: `fsync_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the state to hunt and zeroes all counters. After such an edge `frameLocked` reads 0, even if a head arrives in the same cycle.
- R2: A byte counts as a head only when `byteValid` and `pktStart` are both 1. Every other byte leaves the lock state and the superframe phase unchanged.
- R3: In hunt, a head equal to B8h sets the superframe phase. The marker is then expected on every eighth head after it, and a different phase seen earlier is forgotten.
- R4: Lock is entered on the clock edge that samples the Nth consecutive in-phase B8h marker, where N is `acqThresh`. The first marker, seen in hunt, counts as one of the N.
- R5: During acquisition, two kinds of wrong head send the block back to hunt and clear the marker count. One is a head that is not B8h at the marker slot. The other is a head that is not 47h at any other slot.
- R6: While locked, the right head for each slot is B8h at the marker slot and 47h elsewhere. A right head clears the miss count and any other head adds one. When the miss count reaches `trkThresh`, the block unlocks on that edge.
- R7: A threshold value of 0 acts as 1. A threshold value of 15 is honoured in full.
- R8: `frameLocked` is 1 exactly while the block is in the lock state, whatever the mode input is.
- R9: With `fsyncSel` = 0, `fsyncOut` follows the lock state. With `fsyncSel` = 1, `fsyncOut` follows `upSync`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteIn | input | 8 | Stream byte |
| byteValid | input | 1 | Byte qualifier |
| pktStart | input | 1 | Marks the first byte of a packet |
| acqThresh | input | 4 | Consecutive markers needed to lock (0 acts as 1) |
| trkThresh | input | 4 | Consecutive misses needed to unlock (0 acts as 1) |
| fsyncSel | input | 1 | 0: output shows frame lock; 1: output shows `upSync` |
| upSync | input | 1 | Upstream decoder sync indication |
| fsyncOut | output | 1 | Frame-sync output |
| frameLocked | output | 1 | Frame lock status |

## Verification
The synchronous reset and the decision on a head byte can both act at the same edge. The bench provokes this by holding `rst` high in the very cycle that carries a head which would otherwise be accepted. It then checks that `frameLocked` reads 0 after that edge, and that the next clean marker starts a fresh acquisition. A second coincidence is also exercised: the last marker an acquisition needs arriving with a threshold of 0. The bench expects lock on the same edge that samples the first B8h.

// File: rtl/fsync_pkg.sv
`timescale 1ns/1ps
package fsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2
  } huntState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseLoad;
    logic phaseAdv;
    logic hitInc;
    logic hitClr;
    logic missInc;
    logic missClr;
  } fsStrobe_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic headEv;
    logic atSlot;
    logic isMarker;
    logic isFill;
    logic hitDone;
    logic missDone;
  } fsFlags_t;

endpackage

// File: rtl/fs_datapath.sv
`timescale 1ns/1ps
module fs_datapath
  import fsync_pkg::*;
#(
  parameter int          GROUP_PKTS = 8,
  parameter int          THR_W      = 4,
  parameter logic [7:0]  MARK_BYTE  = 8'hB8,
  parameter logic [7:0]  FILL_BYTE  = 8'h47
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       byteIn,
  input  logic             byteValid,
  input  logic             pktStart,
  input  logic [THR_W-1:0] acqThresh,
  input  logic [THR_W-1:0] trkThresh,
  input  fsStrobe_t        strb,
  output fsFlags_t         flg,
  output logic [THR_W-1:0] missCnt
);

  localparam int               IDX_W    = (GROUP_PKTS > 1) ? $clog2(GROUP_PKTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_PKTS - 1);
  localparam logic [THR_W:0]   ONE_X    = (THR_W+1)'(1);

  logic [IDX_W-1:0] pktIdx;
  logic [THR_W-1:0] hitCnt;
  logic [THR_W-1:0] acqEff, trkEff;

  // a zero threshold behaves like one
  assign acqEff = (acqThresh == '0) ? THR_W'(1) : acqThresh;
  assign trkEff = (trkThresh == '0) ? THR_W'(1) : trkThresh;

  always_comb begin
    flg.headEv   = byteValid && pktStart;
    flg.atSlot   = (pktIdx == LAST_IDX);
    flg.isMarker = (byteIn == MARK_BYTE);
    flg.isFill   = (byteIn == FILL_BYTE);
    flg.hitDone  = ({1'b0, hitCnt} + ONE_X) >= {1'b0, acqEff};
    flg.missDone = ({1'b0, missCnt} + ONE_X) >= {1'b0, trkEff};
  end

  // packet position inside the superframe
  always_ff @(posedge clk) begin
    if (rst) begin
      pktIdx <= '0;
    end else if (strb.phaseLoad) begin
      pktIdx <= '0;
    end else if (strb.phaseAdv) begin
      pktIdx <= (pktIdx == LAST_IDX) ? '0 : pktIdx + IDX_W'(1);
    end
  end

  // consecutive marker and miss counters, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      if (strb.hitClr)                     hitCnt <= '0;
      else if (strb.hitInc && hitCnt != '1) hitCnt <= hitCnt + THR_W'(1);
      if (strb.missClr)                      missCnt <= '0;
      else if (strb.missInc && missCnt != '1) missCnt <= missCnt + THR_W'(1);
    end
  end

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flg.headEv |=> $stable(pktIdx));

  // R3
  phase_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.phaseLoad |-> (flg.headEv && flg.isMarker));

endmodule

// File: rtl/fs_control.sv
`timescale 1ns/1ps
module fs_control
  import fsync_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  fsFlags_t  flg,
  output fsStrobe_t strb,
  output logic      lockQ
);

  huntState_t state, nxt;
  logic       goodHead;

  assign goodHead = flg.atSlot ? flg.isMarker : flg.isFill;

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_HUNT: begin
        if (flg.headEv && flg.isMarker) begin
          strb.phaseLoad = 1'b1;
          strb.hitInc    = 1'b1;
          nxt            = flg.hitDone ? ST_LOCK : ST_ACQ;
        end
      end
      ST_ACQ: begin
        if (flg.headEv) begin
          strb.phaseAdv = 1'b1;
          if (flg.atSlot) begin
            if (flg.isMarker) begin
              strb.hitInc = 1'b1;
              if (flg.hitDone) nxt = ST_LOCK;
            end else begin
              strb.hitClr = 1'b1;
              nxt         = ST_HUNT;
            end
          end else if (!flg.isFill) begin
            strb.hitClr = 1'b1;
            nxt         = ST_HUNT;
          end
        end
      end
      ST_LOCK: begin
        if (flg.headEv) begin
          strb.phaseAdv = 1'b1;
          if (goodHead) begin
            strb.missClr = 1'b1;
          end else if (flg.missDone) begin
            strb.missClr = 1'b1;
            strb.hitClr  = 1'b1;
            nxt          = ST_HUNT;
          end else begin
            strb.missInc = 1'b1;
          end
        end
      end
      default: begin
        strb.hitClr  = 1'b1;
        strb.missClr = 1'b1;
        nxt          = ST_HUNT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      lockQ <= 1'b0;
    end else begin
      state <= nxt;
      lockQ <= (nxt == ST_LOCK);
    end
  end

  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lockQ) |-> $past(flg.headEv && flg.isMarker));

  // R6
  lock_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(lockQ) && !$past(rst)) |->
      $past(flg.headEv && !(flg.atSlot ? flg.isMarker : flg.isFill)));

endmodule

// File: rtl/fsync_tracker.sv
`timescale 1ns/1ps
module fsync_tracker
  import fsync_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       byteIn,
  input  logic             byteValid,
  input  logic             pktStart,
  input  logic [THR_W-1:0] acqThresh,
  input  logic [THR_W-1:0] trkThresh,
  input  logic             fsyncSel,
  input  logic             upSync,
  output logic             fsyncOut,
  output logic             frameLocked
);

  fsStrobe_t        strb;
  fsFlags_t         flg;
  logic [THR_W-1:0] missCnt;
  logic             lockQ;

  fs_datapath #(
    .GROUP_PKTS (8),
    .THR_W      (THR_W),
    .MARK_BYTE  (8'hB8),
    .FILL_BYTE  (8'h47)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .byteIn    (byteIn),
    .byteValid (byteValid),
    .pktStart  (pktStart),
    .acqThresh (acqThresh),
    .trkThresh (trkThresh),
    .strb      (strb),
    .flg       (flg),
    .missCnt   (missCnt)
  );

  fs_control u_ctl (
    .clk   (clk),
    .rst   (rst),
    .flg   (flg),
    .strb  (strb),
    .lockQ (lockQ)
  );

  assign frameLocked = lockQ;
  assign fsyncOut    = fsyncSel ? upSync : lockQ;

  // R6
  unlocked_miss_chk: assert property (@(posedge clk) disable iff (rst)
    !frameLocked |-> (missCnt == '0));

endmodule

// File: tb/fsync_tracker_tb.sv
`timescale 1ns/1ps
module fsync_tracker_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byteIn = 8'h00;
  logic       byteValid = 1'b0;
  logic       pktStart = 1'b0;
  logic [3:0] acqThresh = 4'd3;
  logic [3:0] trkThresh = 4'd2;
  logic       fsyncSel = 1'b0;
  logic       upSync = 1'b0;
  logic       fsyncOut, frameLocked;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  fsync_tracker u_dut (
    .clk(clk), .rst(rst), .byteIn(byteIn), .byteValid(byteValid),
    .pktStart(pktStart), .acqThresh(acqThresh), .trkThresh(trkThresh),
    .fsyncSel(fsyncSel), .upSync(upSync), .fsyncOut(fsyncOut),
    .frameLocked(frameLocked)
  );

  // {rep[3:0], valid, start, byte[7:0], expected lock}, acq=3 trk=2
  localparam logic [14:0] VEC [14] = '{
    {4'd1, 1'b1, 1'b1, 8'h47, 1'b0},
    {4'd1, 1'b0, 1'b1, 8'hB8, 1'b0},
    {4'd1, 1'b1, 1'b0, 8'hB8, 1'b0},
    {4'd1, 1'b1, 1'b1, 8'hB8, 1'b0},
    {4'd7, 1'b1, 1'b1, 8'h47, 1'b0},
    {4'd1, 1'b1, 1'b1, 8'hB8, 1'b0},
    {4'd7, 1'b1, 1'b1, 8'h47, 1'b0},
    {4'd1, 1'b1, 1'b1, 8'hB8, 1'b1},
    {4'd7, 1'b1, 1'b1, 8'h47, 1'b1},
    {4'd1, 1'b1, 1'b1, 8'h00, 1'b1},
    {4'd7, 1'b1, 1'b1, 8'h47, 1'b1},
    {4'd1, 1'b1, 1'b1, 8'hB8, 1'b1},
    {4'd1, 1'b1, 1'b1, 8'h12, 1'b1},
    {4'd1, 1'b1, 1'b1, 8'h13, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic [7:0] b);
    @(negedge clk);
    byteValid = v; pktStart = s; byteIn = b;
    @(posedge clk);
    #2;
    byteValid = 1'b0; pktStart = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 8'h47);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset();
    chk("R1 reset status", frameLocked, 1'b0);
    chk("R1 reset fsync", fsyncOut, 1'b0);

    // table walk: R2 R3 R4 R6 R9
    for (int k = 0; k < 14; k++) begin
      for (int r = 0; r < int'(VEC[k][14:11]); r++) begin
        drive(VEC[k][10], VEC[k][9], VEC[k][8:1]);
        chk($sformatf("R2 R4 R6 table step %0d status", k), frameLocked, VEC[k][0]);
        chk($sformatf("R9 table step %0d fsync", k), fsyncOut, VEC[k][0]);
      end
    end

    // R7 zero thresholds act as one
    acqThresh = 4'd0; trkThresh = 4'd0;
    doReset();
    drive(1'b1, 1'b1, 8'hB8);
    chk("R7 acq zero locks on first marker", frameLocked, 1'b1);
    fill(7);
    chk("R7 lock held over fill heads", frameLocked, 1'b1);
    drive(1'b1, 1'b1, 8'h00);
    chk("R7 trk zero unlocks on first miss", frameLocked, 1'b0);

    // R7 maximum threshold of fifteen
    acqThresh = 4'd15; trkThresh = 4'd15;
    doReset();
    drive(1'b1, 1'b1, 8'hB8);
    for (int g = 0; g < 14; g++) begin
      fill(7);
      drive(1'b1, 1'b1, 8'hB8);
      chk($sformatf("R7 R4 marker %0d of 15", g + 2), frameLocked, (g == 13));
    end

    // R5 wrong head mid-group, R3 re-phase on next marker
    acqThresh = 4'd2; trkThresh = 4'd1;
    doReset();
    drive(1'b1, 1'b1, 8'hB8);
    fill(3);
    drive(1'b1, 1'b1, 8'h55);
    chk("R5 bad fill head drops acquisition", frameLocked, 1'b0);
    fill(2);
    drive(1'b1, 1'b1, 8'hB8);
    fill(7);
    drive(1'b1, 1'b1, 8'hB8);
    chk("R3 new phase from later marker locks", frameLocked, 1'b1);

    // R5 missing marker at slot during acquisition
    doReset();
    drive(1'b1, 1'b1, 8'hB8);
    fill(7);
    drive(1'b1, 1'b1, 8'h47);
    chk("R5 missing marker drops acquisition", frameLocked, 1'b0);
    drive(1'b1, 1'b1, 8'hB8);
    chk("R5 count restarted after drop", frameLocked, 1'b0);
    fill(7);
    drive(1'b1, 1'b1, 8'hB8);
    chk("R4 lock after restart", frameLocked, 1'b1);

    // R8 R9 mode select while locked
    fsyncSel = 1'b1; upSync = 1'b0; #1;
    chk("R9 upstream low selected", fsyncOut, 1'b0);
    chk("R8 status independent of mode", frameLocked, 1'b1);
    upSync = 1'b1; #1;
    chk("R9 upstream high selected", fsyncOut, 1'b1);
    fsyncSel = 1'b0; upSync = 1'b0; #1;
    chk("R9 lock selected", fsyncOut, 1'b1);

    // R1 reset coinciding with an acceptable head
    acqThresh = 4'd0;
    @(negedge clk);
    rst = 1'b1; byteValid = 1'b1; pktStart = 1'b1; byteIn = 8'hB8;
    @(posedge clk);
    #2;
    rst = 1'b0; byteValid = 1'b0; pktStart = 1'b0;
    chk("R1 reset wins over same-cycle head", frameLocked, 1'b0);
    drive(1'b0, 1'b0, 8'h00);
    chk("R1 stays unlocked after reset", frameLocked, 1'b0);
    drive(1'b1, 1'b1, 8'hB8);
    chk("R1 fresh acquisition after reset", frameLocked, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule